// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side. The first uses a history of recent outcomes kept per branch. The second uses one history of recent outcomes shared by all branches. A table of chooser counters, indexed by branch address, decides for each branch which of the two predictions to pass on. The fetch stage presents a PC on the lookup port. In the same cycle it gets back the final direction, both component predictions and which component was picked.

When the branch resolves, the pipeline sends an update carrying the branch PC, the real outcome, and the two component predictions that were reported at lookup time. On the next clock edge the update trains both component counter tables. It also shifts the outcome into the shared history register and into the branch's own local history entry. If the two components disagreed, the update moves the chooser counter toward the one that was right.

The update port is a valid/ready stream. The block never applies back-pressure: `upd_ready` is high in every cycle, including during reset. An update is consumed on each rising edge at which `upd_valid` is high. The lookup port has no handshake. It is a pure function of the PC and the current state.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, every component counter and every chooser counter holds 1, and the shared history and all local histories hold 0. Until the first update, every lookup therefore returns taken=0, sel_global=0, local=0 and global=0.
- R2: Lookup is combinational. The outputs reflect `lk_pc` in the cycle it is presented. An accepted update changes them from the next rising edge onward.
- R3: A chooser counter value of 0 or 1 selects the local component (`pred_sel_global`=0). A value of 2 or 3 selects the global component. `pred_taken` equals the selected component's prediction. A component predicts taken when its 2-bit counter is 2 or 3.
- R4: On an update where `upd_local_pred` differs from `upd_global_pred`, the chooser counter at `upd_pc[7:2]` rises by 1 if the global prediction matched the outcome, and falls by 1 if the local one did. It saturates at 0 and 3. When the two predictions agree, the chooser counter is not changed.
- R5: Every update trains both component counters toward the outcome: +1 when taken, -1 when not taken, saturating at 0 and 3. This happens whichever component was selected.
- R6: Every update shifts the outcome into bit 0 of the 6-bit shared history register. The older bits move up by one.
- R7: Every update shifts the outcome into bit 0 of the 6-bit local history entry selected by `upd_pc[5:2]`. Branches whose PCs share those bits share one entry.
- R8: The global counter table is indexed by the shared history XOR `pc[7:2]`. The local counter table is indexed by the 6-bit local history of the branch.
- R9: `upd_ready` is always 1. A cycle with `upd_valid` low changes no state, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch PC to predict |
| pred_taken | output | 1 | Final predicted direction |
| pred_sel_global | output | 1 | 1 when the global component was chosen |
| pred_local | output | 1 | Local component prediction |
| pred_global | output | 1 | Global component prediction |
| upd_valid | input | 1 | Update present |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_local_pred | input | 1 | Local prediction reported at lookup |
| upd_global_pred | input | 1 | Global prediction reported at lookup |

## Verification
The bench drives the chooser into both saturation limits and back with repeated disagreeing updates. A design with a wrong-direction or non-saturating chooser would pick the wrong component or wrap to the opposite end. Agreeing updates are mixed in, so a chooser that moves on agreement would change selection when it should not. Two PCs that share a local history entry but have different chooser entries show whether history aliasing and XOR global indexing land on the right counters. Idle cycles that carry garbage update fields catch a design that acts without `upd_valid`.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_MAX = 2'd3;
  localparam ctr2_t CTR_MIN = 2'd0;
  localparam ctr2_t CTR_WEAK_LO = 2'd1;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? c : c + 2'd1;
    else    r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_says_taken(input ctr2_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
`timescale 1ns/1ps
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter logic [1:0] RST_VAL = 2'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ctr2_t'(RST_VAL);
    end else if (wr_en) begin
      cells[wr_idx] <= ctr_step(cells[wr_idx], wr_up);
    end
  end

  assign rd_val = cells[rd_idx];

  AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rd_idx) -> $stable(rd_val))); // R9

  AST_TBL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && rd_idx == wr_idx && rd_val != CTR_MAX) |=>
      ($stable(rd_idx) -> (rd_val == $past(rd_val) + 2'd1))); // R5
endmodule

// File: rtl/tp_hist_table.sv
`timescale 1ns/1ps
module tp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
    end else if (wr_en) begin
      rows[wr_idx] <= {rows[wr_idx][HIST_W-2:0], wr_bit};
    end
  end

  assign rd_hist = rows[rd_idx];
  assign wr_hist = rows[wr_idx];

  AST_LHT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($stable(wr_idx) ->
      (wr_hist[0] == $past(wr_bit) && wr_hist[HIST_W-1:1] == $past(wr_hist[HIST_W-2:0])))); // R7
endmodule

// File: rtl/tourney_predictor.sv
`timescale 1ns/1ps
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LHT_IDX_W = 4,
  parameter int LHIST_W   = 6,
  parameter int GHIST_W   = 6,
  parameter int CHO_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic            pred_sel_global,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local_pred,
  input  logic            upd_global_pred
);
  localparam int PC_LSB = 2;

  logic upd_fire;
  logic [GHIST_W-1:0] ghr;

  logic [LHIST_W-1:0] lk_lhist, up_lhist;
  logic [GHIST_W-1:0] lk_gidx, up_gidx;
  ctr2_t lk_lctr, lk_gctr, lk_cctr;
  logic  disagree;

  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid & upd_ready;
  assign disagree  = upd_local_pred ^ upd_global_pred;

  always_ff @(posedge clk) begin
    if (!rst_n) ghr <= '0;
    else if (upd_fire) ghr <= {ghr[GHIST_W-2:0], upd_taken};
  end

  assign lk_gidx = ghr ^ lk_pc[PC_LSB +: GHIST_W];
  assign up_gidx = ghr ^ upd_pc[PC_LSB +: GHIST_W];

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_pc[PC_LSB +: LHT_IDX_W]), .rd_hist(lk_lhist),
    .wr_en(upd_fire), .wr_idx(upd_pc[PC_LSB +: LHT_IDX_W]),
    .wr_bit(upd_taken), .wr_hist(up_lhist)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .RST_VAL(CTR_WEAK_LO)) u_lct (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lhist), .rd_val(lk_lctr),
    .wr_en(upd_fire), .wr_idx(up_lhist), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .RST_VAL(CTR_WEAK_LO)) u_gct (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_gidx), .rd_val(lk_gctr),
    .wr_en(upd_fire), .wr_idx(up_gidx), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(CHO_IDX_W), .RST_VAL(CTR_WEAK_LO)) u_cho (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_pc[PC_LSB +: CHO_IDX_W]), .rd_val(lk_cctr),
    .wr_en(upd_fire & disagree), .wr_idx(upd_pc[PC_LSB +: CHO_IDX_W]),
    .wr_up(upd_global_pred == upd_taken)
  );

  assign pred_local      = ctr_says_taken(lk_lctr);
  assign pred_global     = ctr_says_taken(lk_gctr);
  assign pred_sel_global = ctr_says_taken(lk_cctr);
  assign pred_taken      = pred_sel_global ? pred_global : pred_local;

  AST_GHR_IN: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> ghr[0] == $past(upd_taken)); // R6

  AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(ghr)); // R9

  AST_CHO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_fire || !disagree) |=> ($stable(lk_pc) -> $stable(pred_sel_global))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(lk_pc) -> $stable(pred_taken))); // R9
endmodule

// File: tb/tourney_predictor_tb_top.sv
`timescale 1ns/1ps
module tourney_predictor_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] lk_pc, upd_pc;
  logic pred_taken, pred_sel_global, pred_local, pred_global;
  logic upd_valid, upd_ready, upd_taken, upd_local_pred, upd_global_pred;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  logic [1:0] m_lct [64];
  logic [1:0] m_gct [64];
  logic [1:0] m_cho [64];
  logic [5:0] m_lht [16];
  logic [5:0] m_ghr;

  always #2.5 clk = ~clk;

  tourney_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .pred_taken(pred_taken), .pred_sel_global(pred_sel_global),
    .pred_local(pred_local), .pred_global(pred_global),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_local_pred(upd_local_pred),
    .upd_global_pred(upd_global_pred)
  );

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // expected {taken, sel_global, local, global}
  function automatic logic [3:0] model_look(input logic [31:0] pc);
    logic l, g, s;
    l = m_lct[m_lht[pc[5:2]]][1];
    g = m_gct[m_ghr ^ pc[7:2]][1];
    s = m_cho[pc[7:2]][1];
    return {s ? g : l, s, l, g};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin
      m_lct[i] = 2'd1; m_gct[i] = 2'd1; m_cho[i] = 2'd1;
    end
    for (int i = 0; i < 16; i++) m_lht[i] = '0;
    m_ghr = '0;
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t,
                              input logic lp, input logic gp);
    logic [5:0] h;
    h = m_lht[pc[5:2]];
    m_lct[h] = sat(m_lct[h], t);
    m_gct[m_ghr ^ pc[7:2]] = sat(m_gct[m_ghr ^ pc[7:2]], t);
    if (lp != gp) m_cho[pc[7:2]] = sat(m_cho[pc[7:2]], gp == t);
    m_lht[pc[5:2]] = {h[4:0], t};
    m_ghr = {m_ghr[4:0], t};
  endtask

  // driver: one cycle of lookup plus optional update
  task automatic step(input logic [31:0] lpc, input logic uv, input logic [31:0] upc,
                      input logic ut, input logic ulp, input logic ugp, input string tag);
    @(negedge clk);
    lk_pc = lpc; upd_valid = uv; upd_pc = upc;
    upd_taken = ut; upd_local_pred = ulp; upd_global_pred = ugp;
    exp_q.push_back(model_look(lpc));
    tag_q.push_back(tag);
    if (uv) model_update(upc, ut, ulp, ugp);
  endtask

  // update with the predictions the model reports for that PC, lookup same PC
  task automatic train(input logic [31:0] pc, input logic t, input string tag);
    logic [3:0] p;
    p = model_look(pc);
    step(pc, 1'b1, pc, t, p[1], p[0], tag);
  endtask

  // monitor: compare just before the next rising edge
  initial begin
    logic [3:0] e;
    string tg;
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if ({pred_taken, pred_sel_global, pred_local, pred_global} !== e) begin
          failures++;
          $display("FAIL %s lk_pc=%h actual=%b expected=%b", tg, lk_pc,
                   {pred_taken, pred_sel_global, pred_local, pred_global}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] rpc;
    logic [3:0] p;
    rst_n = 1'b0; lk_pc = '0; upd_pc = '0; upd_valid = 1'b0;
    upd_taken = 1'b0; upd_local_pred = 1'b0; upd_global_pred = 1'b0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    step(32'h0000_0000, 1'b0, 0, 0, 0, 0, "R1");
    step(32'h0000_0104, 1'b0, 0, 0, 0, 0, "R1");
    step(32'hFFFF_FFFC, 1'b0, 0, 0, 0, 0, "R1");
    step(32'h0000_0238, 1'b0, 0, 0, 0, 0, "R1");

    // R9: ready never drops
    @(negedge clk); #1;
    checks++;
    if (upd_ready !== 1'b1) begin
      failures++;
      $display("FAIL R9 upd_ready actual=%b expected=1", upd_ready);
    end

    // R2 / R5: always-taken branch, results visible from next edge
    for (int i = 0; i < 6; i++) train(32'h0000_0100, 1'b1, "R5");
    step(32'h0000_0100, 1'b0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) train(32'h0000_0100, 1'b0, "R5");

    // R9: garbage update fields with valid low
    step(32'h0000_0100, 1'b0, 32'h0000_0100, 1'b1, 1'b0, 1'b1, "R9");
    step(32'h0000_0100, 1'b0, 32'h0000_0240, 1'b1, 1'b0, 1'b1, "R9");
    step(32'h0000_0240, 1'b0, 32'h0000_0240, 1'b0, 1'b1, 1'b0, "R9");

    // R3 / R4: drive chooser up to saturation, then down
    for (int i = 0; i < 5; i++) step(32'h0000_0240, 1'b1, 32'h0000_0240, 1'b1, 1'b0, 1'b1, "R4");
    step(32'h0000_0240, 1'b0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(32'h0000_0240, 1'b1, 32'h0000_0240, 1'b0, 1'b1, 1'b1, "R4");
    for (int i = 0; i < 5; i++) step(32'h0000_0240, 1'b1, 32'h0000_0240, 1'b1, 1'b1, 1'b0, "R4");
    step(32'h0000_0240, 1'b0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(32'h0000_0240, 1'b1, 32'h0000_0240, 1'b0, 1'b0, 1'b1, "R4");

    // R6: alternating outcomes exercise the shared history
    for (int i = 0; i < 20; i++) train(32'h0000_0380, i[0], "R6");

    // R7: 0x10 and 0x50 share a local history entry
    for (int i = 0; i < 8; i++) begin
      train(32'h0000_0010, 1'b1, "R7");
      train(32'h0000_0050, i[1], "R7");
    end

    // R8: pseudo-random mix of PCs and outcomes
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rpc = {24'h0, lfsr[7:0]} & 32'h0000_00FC;
      p = model_look(rpc);
      if (lfsr[9])
        step(rpc, 1'b1, rpc, lfsr[8] ^ lfsr[11], p[1] ^ lfsr[14], p[0], "R8");
      else
        step(rpc ^ 32'h0000_0044, lfsr[10], rpc, lfsr[8], p[1], p[0] ^ lfsr[12], "R8");
    end

    @(negedge clk);
    upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule